// File: doc/BRIEF.md
# JTAG Debug Transport Block

This block sits behind a chip's JTAG pins and gives an external debugger a path into an on-chip debug module. A standard 16-state test access port controller, clocked by TCK, steers scans into a 5-bit instruction register or into one of three data registers. These are a fixed identification word, a read-only transport status word, and a wide access register that carries a debug-bus operation, its data and its address.

When a scan of the access register reaches Update-DR, the shifted word becomes a one-cycle request on a simple parallel bus. The op field selects the request type. A read raises `dbg_rd`. A read-then-write raises `dbg_rd` and `dbg_wr` together, and the returned `dbg_rdata` is the value before the write. A no-op raises nothing.

The block keeps the outcome in a held register. The next Capture-DR of the access register loads this value, so the debugger collects the read data, together with a success status, in its next scan. TDO is launched on the falling TCK edge and is driven low outside the shift states.

Top module: `jtag_dbg_xport`

## Requirements
- R1: The controller follows the standard TAP transition table on rising TCK. Five TCK edges with TMS=1 reach Test-Logic-Reset from any state, including Shift-DR, and a Pause-DR/Exit2-DR detour inside a DR scan does not disturb the shifted data.
- R2: Reset or Test-Logic-Reset selects instruction 0x01. That instruction captures the 32-bit word 0xDEADBEEF, shifted out LSB first.
- R3: Capture-IR loads 5'b00001, so the first five bits out of an IR scan are 1,0,0,0,0. The active instruction changes only in Update-IR or Test-Logic-Reset.
- R4: Instruction 0x10 captures a 32-bit status word. Bits [3:0] hold version 1, bits [9:4] hold ABITS, and all other bits are zero: bus status [11:10] is success, the idle hint [14:12] is 0 and the bus reset request bit 16 is 0.
- R5: Instruction 0x11 selects an ABITS+34-bit register with op in [1:0], data in [33:2] and address in [ABITS+33:34]. Its held value is zero after reset, and every field, up to the highest address, comes back at its own position.
- R6: Op 1 (read) issues a single-cycle `dbg_rd` at the shifted address. The held data field then takes `dbg_rdata`.
- R7: Op 2 (read-then-write) issues `dbg_rd` and `dbg_wr` in the same cycle, with the shifted data on `dbg_wdata`. The held data field takes the pre-write read value.
- R8: Op 0 (no-op) and op 3 (reserved) issue no bus strobe. The held register then takes the shifted address and data.
- R9: The bus strobes rise only in Update-DR while instruction 0x11 is active, for one TCK cycle per update. After any update the held op field reads 0 (success).
- R10: Capture-DR under an instruction other than 0x01, 0x10 or 0x11 leaves the shift register and its length unchanged.
- R11: TDO changes only on the falling TCK edge. `tdo_en` is high exactly while the controller is in Shift-DR or Shift-IR, and TDO is 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, launched on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| dbg_addr | output | ABITS | Debug-bus address |
| dbg_wdata | output | 32 | Debug-bus write data |
| dbg_rd | output | 1 | Debug-bus read strobe |
| dbg_wr | output | 1 | Debug-bus write strobe |
| dbg_rdata | input | 32 | Debug-bus read data, same cycle as the strobe |

## Verification
The bench builds the block with its default ABITS=6. This gives a 40-bit access chain and a 64-word register file behind the bus, so a read of the top address 63 exercises the last address bit of the chain. Read-then-write is confirmed twice: a read of the same word shows the old value, and a later capture shows the new one. Reserved and no-op codes are confirmed to produce no strobe. Scans that abort into reset, pause mid-shift, or run under an unknown instruction exercise the controller paths outside the plain scan sequence.

// File: rtl/jdt_pkg.sv
package jdt_pkg;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  localparam int IR_W = 5;
  localparam int DATA_W = 32;
  localparam int OP_W = 2;

  localparam logic [IR_W-1:0] INS_ID  = 5'h01;
  localparam logic [IR_W-1:0] INS_CTL = 5'h10;
  localparam logic [IR_W-1:0] INS_BUS = 5'h11;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  localparam logic [OP_W-1:0] OP_NOP = 2'd0;
  localparam logic [OP_W-1:0] OP_RD  = 2'd1;
  localparam logic [OP_W-1:0] OP_RW  = 2'd2;
  localparam logic [OP_W-1:0] ST_OK  = 2'd0;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      S_TLR:    n = m ? S_TLR    : S_RTI;
      S_RTI:    n = m ? S_SEL_DR : S_RTI;
      S_SEL_DR: n = m ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: n = m ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  n = m ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: n = m ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: n = m ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: n = m ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: n = m ? S_SEL_DR : S_RTI;
      S_SEL_IR: n = m ? S_TLR    : S_CAP_IR;
      S_CAP_IR: n = m ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  n = m ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: n = m ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: n = m ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: n = m ? S_UPD_IR : S_SH_IR;
      default:  n = m ? S_SEL_DR : S_RTI;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jdt_rst_sync.sv
module jdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/jdt_tap_fsm.sv
module jdt_tap_fsm
  import jdt_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = tap_next(state_q, tms);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= S_TLR;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/jdt_ir.sv
module jdt_ir
  import jdt_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir,
  output logic            ir_lsb
);
  logic [IR_W-1:0] sh_q, sh_d, ir_q, ir_d;
  logic            sh_en, ir_en;

  always_comb begin
    sh_en = 1'b0;
    sh_d  = sh_q;
    if (state == S_CAP_IR) begin
      sh_en = 1'b1;
      sh_d  = IR_CAPTURE;
    end else if (state == S_SH_IR) begin
      sh_en = 1'b1;
      sh_d  = {tdi, sh_q[IR_W-1:1]};
    end
  end

  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir_q;
    if (state == S_TLR) begin
      ir_en = 1'b1;
      ir_d  = INS_ID;
    end else if (state == S_UPD_IR) begin
      ir_en = 1'b1;
      ir_d  = sh_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      ir_q <= INS_ID;
    end else begin
      if (sh_en) sh_q <= sh_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  assign ir     = ir_q;
  assign ir_lsb = sh_q[0];
endmodule

// File: rtl/jdt_dr.sv
module jdt_dr
  import jdt_pkg::*;
#(
  parameter int          ABITS   = 6,
  parameter logic [31:0] IDCODE  = 32'hDEADBEEF,
  parameter int          VERSION = 1
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  input  tap_state_e        state,
  input  logic [IR_W-1:0]   ir,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              dr_lsb,
  output logic [ABITS-1:0]  bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr
);
  localparam int DRW   = ABITS + DATA_W + OP_W;
  localparam int PAD_W = DRW - DATA_W;
  localparam int ADR_LO = DATA_W + OP_W;
  localparam logic [DATA_W-1:0] CTL_WORD =
    DATA_W'(VERSION) | (DATA_W'(ABITS) << 4);

  logic [DRW-1:0] sr_q, sr_d, held_q, held_d;
  logic           wide_q, wide_d;
  logic           sr_en, held_en, upd_bus;
  logic [OP_W-1:0] op;

  // Capture and shift path
  always_comb begin
    sr_en  = 1'b0;
    sr_d   = sr_q;
    wide_d = wide_q;
    if (state == S_CAP_DR) begin
      case (ir)
        INS_ID: begin
          sr_en = 1'b1; wide_d = 1'b0; sr_d = {{PAD_W{1'b0}}, IDCODE};
        end
        INS_CTL: begin
          sr_en = 1'b1; wide_d = 1'b0; sr_d = {{PAD_W{1'b0}}, CTL_WORD};
        end
        INS_BUS: begin
          sr_en = 1'b1; wide_d = 1'b1; sr_d = held_q;
        end
        default: sr_en = 1'b0;
      endcase
    end else if (state == S_SH_DR) begin
      sr_en = 1'b1;
      if (wide_q) sr_d = {tdi, sr_q[DRW-1:1]};
      else        sr_d = {sr_q[DRW-1:DATA_W], tdi, sr_q[DATA_W-1:1]};
    end
  end

  // Update: turn the shifted word into a bus request
  assign op        = sr_q[OP_W-1:0];
  assign upd_bus   = (state == S_UPD_DR) && (ir == INS_BUS);
  assign bus_rd    = upd_bus && ((op == OP_RD) || (op == OP_RW));
  assign bus_wr    = upd_bus && (op == OP_RW);
  assign bus_addr  = sr_q[DRW-1:ADR_LO];
  assign bus_wdata = sr_q[ADR_LO-1:OP_W];

  always_comb begin
    held_en = upd_bus;
    held_d  = {sr_q[DRW-1:ADR_LO], (bus_rd ? bus_rdata : sr_q[ADR_LO-1:OP_W]), ST_OK};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      wide_q <= 1'b0;
      held_q <= '0;
    end else begin
      if (sr_en) begin
        sr_q   <= sr_d;
        wide_q <= wide_d;
      end
      if (held_en) held_q <= held_d;
    end
  end

  assign dr_lsb = sr_q[0];
endmodule

// File: rtl/jtag_dbg_xport.sv
module jtag_dbg_xport
  import jdt_pkg::*;
#(
  parameter int          ABITS   = 6,
  parameter logic [31:0] IDCODE  = 32'hDEADBEEF,
  parameter int          VERSION = 1
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  output logic [ABITS-1:0]  dbg_addr,
  output logic [31:0]       dbg_wdata,
  output logic              dbg_rd,
  output logic              dbg_wr,
  input  logic [31:0]       dbg_rdata
);
  logic            rst_s;
  tap_state_e      tap_state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb;
  logic            tdo_q, tdo_d, tdo_en_q, tdo_en_d;

  jdt_rst_sync #(.STAGES(2)) u_rst (
    .clk(tck), .arst_n(trst_n), .srst_n(rst_s)
  );

  jdt_tap_fsm u_fsm (
    .tck(tck), .rst_n(rst_s), .tms(tms), .state(tap_state)
  );

  jdt_ir u_ir (
    .tck(tck), .rst_n(rst_s), .tdi(tdi), .state(tap_state),
    .ir(ir_q), .ir_lsb(ir_lsb)
  );

  jdt_dr #(.ABITS(ABITS), .IDCODE(IDCODE), .VERSION(VERSION)) u_dr (
    .tck(tck), .rst_n(rst_s), .tdi(tdi), .state(tap_state), .ir(ir_q),
    .bus_rdata(dbg_rdata), .dr_lsb(dr_lsb), .bus_addr(dbg_addr),
    .bus_wdata(dbg_wdata), .bus_rd(dbg_rd), .bus_wr(dbg_wr)
  );

  // TDO launch on the falling edge
  always_comb begin
    tdo_en_d = (tap_state == S_SH_DR) || (tap_state == S_SH_IR);
    tdo_d    = (tap_state == S_SH_IR) ? ir_lsb : dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_s) begin
    if (!rst_s) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      tdo_en_q <= tdo_en_d;
    end
  end

  assign tdo    = tdo_en_q & tdo_q;
  assign tdo_en = tdo_en_q;
endmodule

// File: rtl/jdt_checker.sv
module jdt_checker
  import jdt_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir,
  input logic            dbg_rd,
  input logic            dbg_wr,
  input logic            tdo_en
);
  p_tlr_exit_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_TLR) |=> (state == S_TLR || state == S_RTI));

  p_tlr_ir_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_TLR) |=> (ir == INS_ID));

  p_ir_hold_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (state != S_TLR && state != S_UPD_IR) |=> $stable(ir));

  p_single_rd_r6: assert property (@(posedge tck) disable iff (!rst_n)
    dbg_rd |=> !dbg_rd);

  p_wr_with_rd_r7: assert property (@(posedge tck) disable iff (!rst_n)
    dbg_wr |-> dbg_rd);

  p_strobe_window_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (dbg_rd || dbg_wr) |-> (state == S_UPD_DR && ir == INS_BUS));

  p_tdo_en_r11: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == (state == S_SH_DR || state == S_SH_IR));
endmodule

bind jtag_dbg_xport jdt_checker u_chk (
  .tck(tck), .rst_n(rst_s), .state(tap_state), .ir(ir_q),
  .dbg_rd(dbg_rd), .dbg_wr(dbg_wr), .tdo_en(tdo_en)
);

// File: tb/tb_jtag_dbg_xport.sv
`timescale 1ns/1ps
module tb_jtag_dbg_xport;
  localparam int ABITS = 6;
  localparam int DRW = ABITS + 34;
  localparam int MEMN = 1 << ABITS;

  typedef struct packed {
    logic             wr;
    logic [ABITS-1:0] addr;
    logic [31:0]      wdata;
  } req_t;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_en, dbg_rd, dbg_wr;
  logic [ABITS-1:0] dbg_addr;
  logic [31:0] dbg_wdata, dbg_rdata;
  logic [31:0] mem [MEMN];

  int n_cmp = 0;
  int n_bad = 0;
  int r11_bad = 0;
  bit done = 0;
  req_t sb[$];

  always #2 tck = ~tck;

  jtag_dbg_xport #(.ABITS(ABITS)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_en(tdo_en), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rd(dbg_rd), .dbg_wr(dbg_wr), .dbg_rdata(dbg_rdata)
  );

  function automatic logic [31:0] mem_init(input int i);
    return 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
  endfunction

  function automatic logic [63:0] bw(input logic [ABITS-1:0] a,
                                     input logic [31:0] d, input logic [1:0] op);
    return 64'({a, d, op});
  endfunction

  // Register file behind the bus
  assign dbg_rdata = mem[dbg_addr];
  initial for (int i = 0; i < MEMN; i++) mem[i] = mem_init(i);
  always @(posedge tck) if (dbg_wr) mem[dbg_addr] <= dbg_wdata;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pop expected bus requests as strobes appear
  always @(negedge tck) begin
    if (trst_n && (dbg_rd || dbg_wr)) begin
      if (sb.size() == 0) begin
        check("R9 unexpected strobe", {dbg_rd, dbg_wr, 26'd0, dbg_addr}, 64'd0);
      end else begin
        req_t e;
        e = sb.pop_front();
        check(e.wr ? "R7 read-write request" : "R6 read request",
              {dbg_rd, dbg_wr, dbg_addr, (dbg_wr ? dbg_wdata : 32'd0)},
              {1'b1, e.wr, e.addr, (e.wr ? e.wdata : 32'd0)});
      end
    end
  end

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    tms = m; tdi = d; o = tdo;
    @(posedge tck); #1;
    if (tdo !== o) r11_bad++;
  endtask

  task automatic tap_reset();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [4:0] code, output logic [4:0] out);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, code[i], o);
      out[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input int pause_at,
                         output logic [63:0] dout, output logic en_seen);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      step((i == n - 1) || (i == pause_at - 1), din[i], o);
      if (i == 0) en_seen = tdo_en;
      dout[i] = o;
      if (i == pause_at - 1 && i != n - 1) begin
        step(0, 0, o); step(0, 0, o); step(1, 0, o); step(0, 0, o);
      end
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [4:0] ir_out;
    logic [63:0] d;
    logic en, o;

    repeat (3) @(posedge tck);
    #1;
    check("R11 reset tdo_en/tdo", {62'd0, tdo_en, tdo}, 64'd0);
    trst_n = 1'b1;
    repeat (3) @(posedge tck);
    tap_reset();
    check("R11 idle tdo_en low", {63'd0, tdo_en}, 64'd0);

    // R2: reset selects the identification word
    scan_dr(32, 64'd0, 0, d, en);
    check("R2 idcode after reset", d, 64'hDEADBEEF);
    check("R11 tdo_en in shift", {63'd0, en}, 64'd1);

    // R3 / R4
    scan_ir(5'h10, ir_out);
    check("R3 IR capture pattern", {59'd0, ir_out}, 64'h01);
    scan_dr(32, 64'd0, 0, d, en);
    check("R4 status word", d, 64'((ABITS << 4) | 1));

    // Bus access register
    scan_ir(5'h11, ir_out);
    check("R3 IR capture again", {59'd0, ir_out}, 64'h01);
    scan_dr(DRW, bw(6'd5, 32'h0BAD_F00D, 2'd0), 0, d, en);
    check("R5 held value after reset", d, 64'd0);

    sb.push_back('{wr: 1'b0, addr: 6'd3, wdata: 32'd0});
    scan_dr(DRW, bw(6'd3, 32'h1111_2222, 2'd1), 0, d, en);
    check("R8 no-op stores shifted fields", d, bw(6'd5, 32'h0BAD_F00D, 2'd0));

    sb.push_back('{wr: 1'b1, addr: 6'd7, wdata: 32'hCAFE_0007});
    scan_dr(DRW, bw(6'd7, 32'hCAFE_0007, 2'd2), 0, d, en);
    check("R6 read data returned, status 0", d, bw(6'd3, mem_init(3), 2'd0));

    sb.push_back('{wr: 1'b0, addr: 6'd7, wdata: 32'd0});
    scan_dr(DRW, bw(6'd7, 32'd0, 2'd1), 0, d, en);
    check("R7 read-write returns old data", d, bw(6'd7, mem_init(7), 2'd0));

    scan_dr(DRW, bw(6'd9, 32'h5A5A_0009, 2'd3), 0, d, en);
    check("R7 write landed", d, bw(6'd7, 32'hCAFE_0007, 2'd0));

    sb.push_back('{wr: 1'b0, addr: 6'd63, wdata: 32'd0});
    scan_dr(DRW, bw(6'd63, 32'd0, 2'd1), 0, d, en);
    check("R8 reserved op, no strobe, status 0", d, bw(6'd9, 32'h5A5A_0009, 2'd0));

    scan_dr(DRW, bw(6'd0, 32'd0, 2'd0), 0, d, en);
    check("R5 top address read", d, bw(6'd63, mem_init(63), 2'd0));
    check("R9 all requests issued", 64'(sb.size()), 64'd0);

    // R10: unknown instruction keeps shift contents and length
    scan_ir(5'h01, ir_out);
    scan_dr(32, 64'h1234_5678, 0, d, en);
    check("R2 idcode reselected", d, 64'hDEADBEEF);
    scan_ir(5'h1F, ir_out);
    scan_dr(32, 64'd0, 0, d, en);
    check("R10 unknown instr keeps shift reg", d, 64'h1234_5678);

    // R1: escape from Shift-DR with five TMS=1 edges
    scan_ir(5'h10, ir_out);
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
    scan_dr(32, 64'd0, 0, d, en);
    check("R1 TMS reset from Shift-DR", d, 64'hDEADBEEF);

    // R1: pause detour mid-scan
    scan_dr(32, 64'd0, 13, d, en);
    check("R1 pause detour keeps data", d, 64'hDEADBEEF);

    check("R11 tdo stable across rising edges", 64'(r11_bad), 64'd0);
    check("R9 no stray requests", 64'(sb.size()), 64'd0);
    repeat (4) @(posedge tck);
    finish_run();
  end
endmodule